// File: doc/BRIEF.md
# Priority SMT Issue Scheduler

This block decides, in every cycle, which hardware thread slot of a simultaneously multithreaded core may issue into each of the core's two pipelines: an integer pipeline and an address pipeline. Slot 0 holds the hard real-time thread. The other slots, up to three of them, hold threads without timing guarantees. Slot 0 always wins, so its instruction stream sees the same issue timing it would see if it ran alone on the core.

The lower-priority slots share whatever slot 0 leaves unused. They take turns through one rotating pointer per pipeline. A multicycle sequence in a lower-priority slot reserves no pipeline. When slot 0 takes the pipeline, the sequence is paused between micro-steps and carries on once the pipeline is free again. A memory read is split into an access phase and a later write-back phase. While the data is outstanding, the slot makes no requests and leaves both pipelines to the other slots.

Slot 0 also has first claim on the fetch request and on the core's memory-arbiter request. The remaining requesters for those two are served in order of slot number.

Top module: `smt_issue_sched`

## Requirements
- R1: After reset, every slot is in its normal issue phase. Both round-robin pointers point at slot 1. With no inputs active, no grant output is set.
- R2: When slot 0 requests a pipeline, slot 0 is granted that pipeline in the same cycle, whatever the other slots request.
- R3: Each pipeline grants at most one slot per cycle, and it grants only a slot that requests it.
- R4: A slot in its normal phase requests the pipeline named by its head class (class bit 0 means integer, 1 means address). When its second instruction is valid and has the other class, the slot also requests the other pipeline, so one slot may hold both grants in the same cycle.
- R5: If slot 0 does not request a pipeline, that pipeline goes to the first requesting slot found by searching upward from the pipeline's pointer and wrapping from the last slot back to slot 1. After a grant to a lower-priority slot, the pointer moves to the slot after the winner (wrapping to slot 1). The pointer keeps its value in every other cycle, including cycles that slot 0 wins.
- R6: A pipeline with at least one requester always grants someone in that cycle. No cycle is lost to an empty or waiting slot.
- R7: A lower-priority slot flagged as mid-sequence that requests a pipeline slot 0 holds in that cycle sees its pause output high in that cycle. The pause output is low in all other cases, and it is never set for slot 0.
- R8: When a slot's head instruction is a load of address class and it is granted the address pipeline, the slot makes no requests until its memory response arrives. From the cycle after the response, it requests only the address pipeline, for the write-back phase, and it ignores its head inputs. The write-back grant is flagged on the write-back output. The cycle after that grant, the slot is back in its normal phase.
- R9: The fetch grant and the memory-arbiter grant each go to the lowest-numbered requesting slot, which is slot 0 whenever slot 0 requests. At most one grant is given for each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hd_vld | input | NUM_SLOTS | Head instruction of the slot is ready |
| hd_cls | input | NUM_SLOTS | Head class: 0 integer, 1 address |
| hd_ld | input | NUM_SLOTS | Head instruction is a memory read |
| nx_vld | input | NUM_SLOTS | Second instruction of the slot is ready |
| nx_cls | input | NUM_SLOTS | Second instruction class |
| mc_busy | input | NUM_SLOTS | Slot is inside a multicycle micro-step sequence |
| mem_rsp | input | NUM_SLOTS | Read data returned for the slot |
| fetch_req | input | NUM_SLOTS | Fetch request per slot |
| mem_req | input | NUM_SLOTS | Memory-arbiter request per slot |
| gnt_int | output | NUM_SLOTS | Integer pipeline grant, one-hot or zero |
| gnt_adr | output | NUM_SLOTS | Address pipeline grant, one-hot or zero |
| wb_gnt | output | NUM_SLOTS | Address grant is a write-back phase |
| mc_pause | output | NUM_SLOTS | Multicycle sequence paused by slot 0 |
| fetch_gnt | output | NUM_SLOTS | Fetch grant |
| mem_gnt | output | NUM_SLOTS | Memory-arbiter grant |

## Verification
The assertions check the per-cycle rules on every cycle. Slot 0 always wins a pipeline it asks for, the grants are one-hot and go only to requesters, a pipeline with a requester is never idle, a pointer moves only after a lower-priority grant, a slot waiting for read data never requests, and a pause always coincides with a slot-0 grant. The exact rotation order and the full access, wait and write-back sequence can only be shown by the bench's scenarios. The same holds for a write-back that loses to slot 0 and for dual issue by one slot. The bench compares these against an independent model of the slots.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;
  // read-split phase of one slot
  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_WAIT = 2'd1,
    PH_WB   = 2'd2
  } rd_phase_t;

  localparam logic CLS_INT = 1'b0;
  localparam logic CLS_ADR = 1'b1;

  // next round-robin pointer after a grant to slot win, slots 1..nrt
  function automatic int rr_after(input int win, input int nrt);
    return (win >= nrt) ? 1 : win + 1;
  endfunction
endpackage

// File: rtl/smt_slot_phase.sv
module smt_slot_phase
  import smt_issue_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hd_vld,
  input  logic hd_cls,
  input  logic hd_ld,
  input  logic nx_vld,
  input  logic nx_cls,
  input  logic mem_rsp,
  input  logic adr_won,
  output logic req_int,
  output logic req_adr,
  output logic in_wb
);
  rd_phase_t phase;
  logic      start_rd;

  // requests seen by the arbiters
  always_comb begin
    req_int = 1'b0;
    req_adr = 1'b0;
    unique case (phase)
      PH_RUN: begin
        if (hd_vld) begin
          if (hd_cls == CLS_ADR) req_adr = 1'b1;
          else                   req_int = 1'b1;
          if (nx_vld && (nx_cls != hd_cls)) begin
            if (nx_cls == CLS_ADR) req_adr = 1'b1;
            else                   req_int = 1'b1;
          end
        end
      end
      PH_WB:   req_adr = 1'b1;
      default: ;
    endcase
  end

  assign in_wb    = (phase == PH_WB);
  assign start_rd = (phase == PH_RUN) && adr_won && hd_vld && hd_ld && (hd_cls == CLS_ADR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_RUN;
    end else begin
      unique case (phase)
        PH_RUN:  if (start_rd) phase <= PH_WAIT;
        PH_WAIT: if (mem_rsp)  phase <= PH_WB;
        PH_WB:   if (adr_won)  phase <= PH_RUN;
        default: phase <= PH_RUN;
      endcase
    end
  end

  // R8: waiting for data holds until the response arrives
  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT && !mem_rsp) |=> (phase == PH_WAIT));
  // R8: a read access grant leads to a silent wait
  assert_wait_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> (!req_int && !req_adr));
  // R8: write-back asks only for the address pipeline
  assert_wb_adr_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |-> (req_adr && !req_int));
endmodule

// File: rtl/smt_pipe_arb.sv
module smt_pipe_arb
  import smt_issue_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] req,
  output logic [NUM_SLOTS-1:0] gnt
);
  localparam int NRT = NUM_SLOTS - 1;
  localparam int IW  = $clog2(NUM_SLOTS) + 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] win;
  logic          nrt_hit;

  always_comb begin
    logic [IW-1:0] idx;
    gnt     = '0;
    nrt_hit = 1'b0;
    win     = '0;
    idx     = '0;
    if (req[0]) begin
      gnt[0] = 1'b1;
    end else begin
      for (int k = 0; k < NRT; k++) begin
        idx = ptr + IW'(k);
        if (idx > IW'(NRT)) idx = idx - IW'(NRT);
        if (!nrt_hit && req[idx]) begin
          gnt[idx] = 1'b1;
          nrt_hit  = 1'b1;
          win      = idx;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= IW'(1);
    else if (nrt_hit) ptr <= IW'(rr_after(int'(win), NRT));
  end

  assert_hrt_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |-> gnt[0]);
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_only_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_no_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(|gnt[NUM_SLOTS-1:1]) |=> $stable(ptr));
  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= IW'(1)) && (ptr <= IW'(NRT)));
endmodule

// File: rtl/smt_issue_sched.sv
module smt_issue_sched
  import smt_issue_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] hd_vld,
  input  logic [NUM_SLOTS-1:0] hd_cls,
  input  logic [NUM_SLOTS-1:0] hd_ld,
  input  logic [NUM_SLOTS-1:0] nx_vld,
  input  logic [NUM_SLOTS-1:0] nx_cls,
  input  logic [NUM_SLOTS-1:0] mc_busy,
  input  logic [NUM_SLOTS-1:0] mem_rsp,
  input  logic [NUM_SLOTS-1:0] fetch_req,
  input  logic [NUM_SLOTS-1:0] mem_req,
  output logic [NUM_SLOTS-1:0] gnt_int,
  output logic [NUM_SLOTS-1:0] gnt_adr,
  output logic [NUM_SLOTS-1:0] wb_gnt,
  output logic [NUM_SLOTS-1:0] mc_pause,
  output logic [NUM_SLOTS-1:0] fetch_gnt,
  output logic [NUM_SLOTS-1:0] mem_gnt
);
  logic [NUM_SLOTS-1:0] req_int;
  logic [NUM_SLOTS-1:0] req_adr;
  logic [NUM_SLOTS-1:0] in_wb;

  // lowest-numbered requester wins; slot 0 is the real-time slot
  function automatic logic [NUM_SLOTS-1:0] lowest_first(input logic [NUM_SLOTS-1:0] r);
    logic [NUM_SLOTS-1:0] g;
    logic                 hit;
    g   = '0;
    hit = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (!hit && r[s]) begin
        g[s] = 1'b1;
        hit  = 1'b1;
      end
    end
    return g;
  endfunction

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    smt_slot_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .hd_vld  (hd_vld[s]),
      .hd_cls  (hd_cls[s]),
      .hd_ld   (hd_ld[s]),
      .nx_vld  (nx_vld[s]),
      .nx_cls  (nx_cls[s]),
      .mem_rsp (mem_rsp[s]),
      .adr_won (gnt_adr[s]),
      .req_int (req_int[s]),
      .req_adr (req_adr[s]),
      .in_wb   (in_wb[s])
    );
  end

  smt_pipe_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb_int (
    .clk (clk), .rst_n (rst_n), .req (req_int), .gnt (gnt_int)
  );
  smt_pipe_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb_adr (
    .clk (clk), .rst_n (rst_n), .req (req_adr), .gnt (gnt_adr)
  );

  assign wb_gnt = gnt_adr & in_wb;

  always_comb begin
    mc_pause = '0;
    for (int s = 1; s < NUM_SLOTS; s++) begin
      mc_pause[s] = mc_busy[s] && ((req_int[s] && gnt_int[0]) || (req_adr[s] && gnt_adr[0]));
    end
  end

  assign fetch_gnt = lowest_first(fetch_req);
  assign mem_gnt   = lowest_first(mem_req);

  assert_pause_by_hrt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|mc_pause) |-> (gnt_int[0] || gnt_adr[0]));
  assert_pause_not_hrt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_pause[0]);
  assert_fetch_hrt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req[0] |-> (fetch_gnt == NUM_SLOTS'(1)));
  assert_mem_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_gnt) && ((mem_gnt & ~mem_req) == '0));
  assert_wb_on_adr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_gnt & ~gnt_adr) == '0);
endmodule

// File: tb/tb_smt_issue_sched.sv
module tb_smt_issue_sched;
  localparam int N = 4;
  // per-slot stimulus bits: 0 hd_vld,1 hd_cls,2 hd_ld,3 nx_vld,4 nx_cls,5 mc_busy,6 mem_rsp,7 fetch,8 mem
  localparam logic [8:0] Z  = 9'b000000000;
  localparam logic [8:0] I  = 9'b000000001;
  localparam logic [8:0] A  = 9'b000000011;
  localparam logic [8:0] L  = 9'b000000111;
  localparam logic [8:0] D  = 9'b000011001;
  localparam logic [8:0] MC = 9'b000100001;
  localparam logic [8:0] RS = 9'b001000000;
  localparam logic [8:0] F  = 9'b010000000;
  localparam logic [8:0] M  = 9'b100000000;
  localparam int NV = 21;
  localparam logic [3:0][8:0] TBL [NV] = '{
    '{I, I, I, Z}, '{I, I, I, Z}, '{I, I, I, Z}, '{I, I, I, I},
    '{I, Z, I, A}, '{A, I, Z, D}, '{Z, D, I, I}, '{Z, Z, MC, I},
    '{Z, Z, MC, Z}, '{Z, L, Z, Z}, '{I, L, Z, Z}, '{Z, L|RS, Z, Z},
    '{Z, I, Z, A}, '{Z, I, Z, Z}, '{Z, I, Z, Z}, '{F|M, F, Z, M},
    '{Z, Z, Z, Z}, '{Z, Z, Z, L}, '{Z, Z, I, A}, '{Z, Z, Z, RS},
    '{Z, Z, Z, Z}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] hd_vld, hd_cls, hd_ld, nx_vld, nx_cls, mc_busy, mem_rsp, fetch_req, mem_req;
  logic [N-1:0] gnt_int, gnt_adr, wb_gnt, mc_pause, fetch_gnt, mem_gnt;
  int nchk = 0;
  int nfail = 0;
  int m_ptr_i = 1;
  int m_ptr_a = 1;
  int m_ph [N];

  always #10 clk = ~clk;

  smt_issue_sched #(.NUM_SLOTS(N)) dut (
    .clk(clk), .rst_n(rst_n), .hd_vld(hd_vld), .hd_cls(hd_cls), .hd_ld(hd_ld),
    .nx_vld(nx_vld), .nx_cls(nx_cls), .mc_busy(mc_busy), .mem_rsp(mem_rsp),
    .fetch_req(fetch_req), .mem_req(mem_req), .gnt_int(gnt_int), .gnt_adr(gnt_adr),
    .wb_gnt(wb_gnt), .mc_pause(mc_pause), .fetch_gnt(fetch_gnt), .mem_gnt(mem_gnt)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // reference arbitration: slot 0 first, else scan from pointer among slots 1..3
  task automatic ref_arb(input logic [N-1:0] r, inout int p, output logic [N-1:0] g);
    bit found = 0;
    g = '0;
    if (r[0]) g[0] = 1'b1;
    else begin
      for (int k = 0; k < N - 1; k++) begin
        int c = ((p - 1 + k) % (N - 1)) + 1;
        if (!found && r[c]) begin
          g[c] = 1'b1;
          found = 1;
          p = (c % (N - 1)) + 1;
        end
      end
    end
  endtask

  function automatic logic [N-1:0] ref_low(input logic [N-1:0] r);
    for (int s = 0; s < N; s++) if (r[s]) return N'(1) << s;
    return '0;
  endfunction

  task automatic run_vec(input logic [3:0][8:0] v);
    logic [N-1:0] ri, ra, ei, ea, ewb, ep;
    @(negedge clk);
    for (int s = 0; s < N; s++) begin
      hd_vld[s] = v[s][0]; hd_cls[s] = v[s][1]; hd_ld[s] = v[s][2];
      nx_vld[s] = v[s][3]; nx_cls[s] = v[s][4]; mc_busy[s] = v[s][5];
      mem_rsp[s] = v[s][6]; fetch_req[s] = v[s][7]; mem_req[s] = v[s][8];
    end
    ri = '0; ra = '0;
    for (int s = 0; s < N; s++) begin
      if (m_ph[s] == 2) ra[s] = 1'b1;
      else if (m_ph[s] == 0 && v[s][0]) begin
        if (v[s][1]) ra[s] = 1'b1; else ri[s] = 1'b1;
        if (v[s][3] && (v[s][4] != v[s][1])) begin
          if (v[s][4]) ra[s] = 1'b1; else ri[s] = 1'b1;
        end
      end
    end
    ref_arb(ri, m_ptr_i, ei);
    ref_arb(ra, m_ptr_a, ea);
    ewb = '0; ep = '0;
    for (int s = 0; s < N; s++) begin
      ewb[s] = ea[s] && (m_ph[s] == 2);
      if (s > 0) ep[s] = v[s][5] && ((ri[s] && ei[0]) || (ra[s] && ea[0]));
    end
    #1;
    check("R5 integer grant", gnt_int, ei);
    check("R4 address grant", gnt_adr, ea);
    check("R3 one per pipe", N'($countones(gnt_int) <= 1 && $countones(gnt_adr) <= 1), N'(1));
    check("R6 no idle", N'({|gnt_int, |gnt_adr}), N'({|ri, |ra}));
    if (ri[0]) check("R2 real-time slot wins", N'(gnt_int[0]), N'(1));
    check("R8 write-back grant", wb_gnt, ewb);
    check("R7 pause", mc_pause, ep);
    check("R9 fetch", fetch_gnt, ref_low(fetch_req));
    check("R9 memory arbiter", mem_gnt, ref_low(mem_req));
    for (int s = 0; s < N; s++) begin
      if (m_ph[s] == 0 && ea[s] && v[s][0] && v[s][1] && v[s][2]) m_ph[s] = 1;
      else if (m_ph[s] == 1 && v[s][6]) m_ph[s] = 2;
      else if (m_ph[s] == 2 && ea[s]) m_ph[s] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {hd_vld, hd_cls, hd_ld, nx_vld, nx_cls, mc_busy, mem_rsp, fetch_req, mem_req} = '0;
    m_ptr_i = 1; m_ptr_a = 1;
    for (int s = 0; s < N; s++) m_ph[s] = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check("R1 reset outputs", gnt_int | gnt_adr | wb_gnt | mc_pause | fetch_gnt | mem_gnt, '0);
    for (int t = 0; t < NV; t++) run_vec(TBL[t]);
    // directed: reset in the middle of activity restores pointer at slot 1
    run_vec('{L, I, I, Z});
    do_reset();
    run_vec('{I, I, I, Z});
    check("R1 pointer at slot 1", gnt_int, 4'b0010);
    // directed: only one lower-priority requester, pointer past it
    run_vec('{Z, Z, A, Z});
    run_vec('{Z, A, Z, Z});
    check("R6 lone requester served", gnt_adr, 4'b0100);
    // directed: write-back phase ignores head inputs of the slot
    run_vec('{L, Z, Z, Z});
    run_vec('{I|RS, Z, Z, Z});
    run_vec('{I, Z, Z, Z});
    check("R8 write-back ignores head", gnt_int, 4'b0000);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule